// File: doc/BRIEF.md
# Fetch Target Predictor with Return-Address Stack

This block sits beside the instruction fetch unit and, in the same cycle that a fetch address is presented, says whether that address is a known branch, which address to fetch next, and whether the branch is expected to be taken. Known branches are held in a direct-mapped table. The table is indexed by low bits of the fetch address and tagged with the complete address, so a stored target is followed only for the exact branch that installed it.

Every entry records what kind of control transfer it describes. Subroutine calls push their fall-through address onto a small circular return stack. Returns take their target from the top of that stack instead of from the table, which lets one return instruction predict correctly for many different callers.

The back end reports each resolved branch through a correction port: the branch address, its kind, the actual direction and the actual target. That report allocates a table entry or overwrites the existing one. The new contents become visible to lookups from the following cycle.

Top module: `fetch_target_predictor`

## Requirements
- R1: The table index is fetch address bits [IDX_W+1:2]. A lookup hits only if that slot is valid and its stored full address equals the fetch address. Another address that maps to the same slot misses.
- R2: On a miss, or while `fetch_valid` is low, `pred_hit` is 0, `pred_taken` is 0 and `pred_next_pc` is the fetch address plus 4.
- R3: On a hit whose kind is conditional (code 2'b00) or jump (code 2'b01), `pred_hit` is 1 and `pred_taken` equals the stored direction bit. `pred_next_pc` is the stored target when that bit is 1, and the fetch address plus 4 otherwise.
- R4: A correction writes the valid bit, full address, target, direction bit and kind into the slot its address indexes, replacing whatever that slot held before.
- R5: A hit on a call entry (code 2'b10) predicts as in R3 and pushes the fetch address plus 4 onto the return stack.
- R6: A hit on a return entry (code 2'b11) while the stack holds at least one address gives `pred_hit`=1, `pred_taken`=1 and `pred_next_pc` equal to the most recently pushed address. That address is then removed from the stack.
- R7: A correction takes effect at the next rising clock edge. A lookup in the same cycle as a correction to the same slot sees the slot's previous contents.
- R8: A hit on a return entry while the stack is empty gives `pred_hit`=0, `pred_taken`=0 and `pred_next_pc` equal to the fetch address plus 4, and leaves the stack empty.
- R9: The stack holds RAS_DEPTH (default 8) addresses. A push onto a full stack discards the oldest address. Later returns then receive the newest RAS_DEPTH addresses in reverse push order, after which the stack is empty.
- R10: A synchronous active-low reset invalidates every table slot and empties the return stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_valid | input | 1 | A fetch address is being looked up this cycle |
| fetch_pc | input | PC_W | Fetch address to look up |
| pred_hit | output | 1 | A usable prediction was found |
| pred_taken | output | 1 | Predicted direction, 1 means taken |
| pred_next_pc | output | PC_W | Predicted next fetch address |
| fix_valid | input | 1 | A resolved branch is being reported |
| fix_pc | input | PC_W | Address of the resolved branch |
| fix_kind | input | 2 | Branch kind: 00 conditional, 01 jump, 10 call, 11 return |
| fix_taken | input | 1 | Resolved direction |
| fix_target | input | PC_W | Resolved target address |

## Verification
A corrupted tag or valid bit shows up at the outputs the first time the affected address is fetched: a wrong hit flag or a wrong next address in that same cycle. A faulty return-stack pointer or count stays hidden until the next return, and only then gives a wrong target or a wrong hit flag. For that reason the stimulus runs long call/return chains, including an overflow followed by a full drain into an empty stack, as well as aliasing addresses and random corrections. A behavioural reference model is compared against all three outputs on every clock.

// File: rtl/fetch_pred_pkg.sv
// Shared definitions for the fetch target predictor.
// Assumes: the kind codes are fixed because the back end drives them directly.
package fetch_pred_pkg;

    typedef enum logic [1:0] {
        BK_COND = 2'b00,
        BK_JUMP = 2'b01,
        BK_CALL = 2'b10,
        BK_RET  = 2'b11
    } br_kind_e;

endpackage

// File: rtl/btb_store.sv
// Direct-mapped tagged target table.
// What it does: a combinational read port for the fetch address and a
// synchronous write port for corrections.
// Assumes: addresses are 4-byte aligned, so bits [1:0] are not used for the index.
// A read and a write to the same slot in one cycle return the old contents.
module btb_store
    import fetch_pred_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] rd_pc,
    output logic            rd_hit,
    output br_kind_e        rd_kind,
    output logic [PC_W-1:0] rd_target,
    output logic            rd_taken,
    input  logic            wr_en,
    input  logic [PC_W-1:0] wr_pc,
    input  br_kind_e        wr_kind,
    input  logic            wr_taken,
    input  logic [PC_W-1:0] wr_target
);

    localparam int ENTRIES = 1 << IDX_W;

    typedef struct packed {
        logic [PC_W-1:0] tag;
        logic [PC_W-1:0] target;
        logic            taken;
        br_kind_e        kind;
    } slot_t;

    logic [ENTRIES-1:0] vld_q;
    slot_t              slot_q [ENTRIES];
    logic [IDX_W-1:0]   rd_idx;
    logic [IDX_W-1:0]   wr_idx;
    slot_t              rd_slot;

    // Index extraction: word-aligned low address bits.
    always_comb begin
        rd_idx = rd_pc[IDX_W+1:2];
        wr_idx = wr_pc[IDX_W+1:2];
    end

    // Valid bits: cleared by reset, set by a correction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
        end
    end

    // Slot payload: written on a correction, not reset.
    always_ff @(posedge clk) begin
        if (rst_n && wr_en) begin
            slot_q[wr_idx] <= '{tag: wr_pc, target: wr_target,
                                taken: wr_taken, kind: wr_kind};
        end
    end

    // Read port: a full-address tag compare decides the hit.
    always_comb begin
        rd_slot   = slot_q[rd_idx];
        rd_hit    = vld_q[rd_idx] && (rd_slot.tag == rd_pc);
        rd_kind   = rd_slot.kind;
        rd_target = rd_slot.target;
        rd_taken  = rd_slot.taken;
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (vld_q[$past(wr_idx)] && slot_q[$past(wr_idx)].tag == $past(wr_pc))) // R7
        else $error("correction did not land");

    AST_WRITE_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (slot_q[$past(wr_idx)].target == $past(wr_target)
                   && slot_q[$past(wr_idx)].kind == $past(wr_kind))) // R4
        else $error("correction payload mismatch");

endmodule

// File: rtl/ret_stack.sv
// Circular return-address stack.
// What it does: a push stores an address. A push onto a full stack overwrites
// the oldest address. A pop removes the newest address, and a pop on an empty
// stack is ignored.
// Assumes: push and pop are never both asserted; push takes priority if they are.
module ret_stack #(
    parameter int PC_W  = 32,
    parameter int DEPTH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [PC_W-1:0] push_addr,
    input  logic            pop,
    output logic [PC_W-1:0] top_addr,
    output logic            empty
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [PC_W-1:0]  slot_q [DEPTH];
    logic [PTR_W-1:0] wp_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PTR_W-1:0] wp_next;
    logic [PTR_W-1:0] wp_prev;

    // Wrapping neighbours of the write pointer, valid for any depth.
    always_comb begin
        wp_next = (wp_q == LAST) ? '0 : wp_q + PTR_W'(1);
        wp_prev = (wp_q == '0) ? LAST : wp_q - PTR_W'(1);
    end

    // Pointer, occupancy and storage update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            cnt_q <= '0;
        end else if (push) begin
            slot_q[wp_q] <= push_addr;
            wp_q         <= wp_next;
            if (cnt_q != FULL) cnt_q <= cnt_q + CNT_W'(1);
        end else if (pop && cnt_q != '0) begin
            wp_q  <= wp_prev;
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // Read side: the newest address sits just below the write pointer.
    always_comb begin
        top_addr = slot_q[wp_prev];
        empty    = (cnt_q == '0);
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL) // R9
        else $error("stack count beyond depth");

    AST_FULL_PUSH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (push && cnt_q == FULL) |=> (cnt_q == FULL)) // R9
        else $error("overflow push changed count");

    AST_PUSH_ON_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (top_addr == $past(push_addr) && !empty)) // R5
        else $error("pushed address not on top");

    AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))) // R6
        else $error("pop did not shrink stack");

endmodule

// File: rtl/fetch_target_predictor.sv
// Fetch-stage target predictor: a tagged target table plus a return stack.
// What it does: the lookup is combinational in the fetch cycle. A call hit
// pushes the fall-through address; a return hit takes its target from the
// stack, and with an empty stack it is reported as no prediction.
// Assumes: one fetch address per cycle, 4-byte instructions, and corrections
// that arrive no earlier than the branch they describe.
module fetch_target_predictor
    import fetch_pred_pkg::*;
#(
    parameter int PC_W      = 32,
    parameter int IDX_W     = 4,
    parameter int RAS_DEPTH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fetch_valid,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            pred_hit,
    output logic            pred_taken,
    output logic [PC_W-1:0] pred_next_pc,
    input  logic            fix_valid,
    input  logic [PC_W-1:0] fix_pc,
    input  logic [1:0]      fix_kind,
    input  logic            fix_taken,
    input  logic [PC_W-1:0] fix_target
);

    localparam logic [PC_W-1:0] INSN_BYTES = PC_W'(4);

    logic            lk_hit;
    br_kind_e        lk_kind;
    logic [PC_W-1:0] lk_target;
    logic            lk_taken;
    logic [PC_W-1:0] seq_pc;
    logic            tbl_hit;
    logic            is_call;
    logic            is_ret;
    logic            stk_push;
    logic            stk_pop;
    logic [PC_W-1:0] stk_top;
    logic            stk_empty;

    btb_store #(
        .PC_W (PC_W),
        .IDX_W(IDX_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_pc    (fetch_pc),
        .rd_hit   (lk_hit),
        .rd_kind  (lk_kind),
        .rd_target(lk_target),
        .rd_taken (lk_taken),
        .wr_en    (fix_valid),
        .wr_pc    (fix_pc),
        .wr_kind  (br_kind_e'(fix_kind)),
        .wr_taken (fix_taken),
        .wr_target(fix_target)
    );

    ret_stack #(
        .PC_W (PC_W),
        .DEPTH(RAS_DEPTH)
    ) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (stk_push),
        .push_addr(seq_pc),
        .pop      (stk_pop),
        .top_addr (stk_top),
        .empty    (stk_empty)
    );

    // Classify the lookup and derive the stack operations.
    always_comb begin
        seq_pc   = fetch_pc + INSN_BYTES;
        tbl_hit  = fetch_valid && lk_hit;
        is_call  = tbl_hit && (lk_kind == BK_CALL);
        is_ret   = tbl_hit && (lk_kind == BK_RET);
        stk_push = is_call;
        stk_pop  = is_ret && !stk_empty;
    end

    // Select the prediction: stack for returns, table for the other kinds.
    always_comb begin
        pred_hit     = 1'b0;
        pred_taken   = 1'b0;
        pred_next_pc = seq_pc;
        if (is_ret) begin
            if (!stk_empty) begin
                pred_hit     = 1'b1;
                pred_taken   = 1'b1;
                pred_next_pc = stk_top;
            end
        end else if (tbl_hit) begin
            pred_hit   = 1'b1;
            pred_taken = lk_taken;
            if (lk_taken) pred_next_pc = lk_target;
        end
    end

    AST_MISS_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_hit |-> (!pred_taken && pred_next_pc == fetch_pc + INSN_BYTES)) // R2
        else $error("miss gave a taken prediction");

    AST_EMPTY_RET_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && lk_hit && lk_kind == BK_RET && stk_empty) |-> !pred_hit) // R8
        else $error("return predicted from empty stack");

    AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |-> !pred_hit) // R2
        else $error("hit without a fetch");

endmodule

// File: tb/tb_fetch_target_predictor.sv
`timescale 1ns/1ps
module tb_fetch_target_predictor;

    localparam int PC_W = 32;
    localparam int IDX_W = 4;
    localparam int DEPTH = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            fetch_valid = 1'b0;
    logic [PC_W-1:0] fetch_pc = '0;
    logic            pred_hit;
    logic            pred_taken;
    logic [PC_W-1:0] pred_next_pc;
    logic            fix_valid = 1'b0;
    logic [PC_W-1:0] fix_pc = '0;
    logic [1:0]      fix_kind = '0;
    logic            fix_taken = 1'b0;
    logic [PC_W-1:0] fix_target = '0;

    int checks = 0;
    int errors = 0;

    // Reference model state: slots keyed by index, stack as a queue.
    logic [PC_W-1:0] m_tag  [int];
    logic [PC_W-1:0] m_tgt  [int];
    bit              m_tkn  [int];
    logic [1:0]      m_kind [int];
    logic [PC_W-1:0] m_stk  [$];

    always #2.5 clk = ~clk;

    fetch_target_predictor #(.PC_W(PC_W), .IDX_W(IDX_W), .RAS_DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_next_pc(pred_next_pc),
        .fix_valid(fix_valid), .fix_pc(fix_pc), .fix_kind(fix_kind),
        .fix_taken(fix_taken), .fix_target(fix_target)
    );

    task automatic chk(input string rq, input string what,
                       input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, compare before the rising edge,
    // then advance the model as the rising edge will.
    task automatic step(input bit fv, input logic [PC_W-1:0] fpc,
                        input bit uv, input logic [PC_W-1:0] upc, input logic [1:0] uk,
                        input bit ut, input logic [PC_W-1:0] utgt, input string rq);
        int idx;
        int uidx;
        bit e_hit;
        bit e_tk;
        logic [PC_W-1:0] e_nx;
        string tag;
        @(negedge clk);
        fetch_valid = fv; fetch_pc = fpc;
        fix_valid = uv; fix_pc = upc; fix_kind = uk; fix_taken = ut; fix_target = utgt;
        #1;
        idx = int'(fpc[IDX_W+1:2]);
        e_hit = 1'b0; e_tk = 1'b0; e_nx = fpc + 4; tag = "R2";
        if (fv && m_tag.exists(idx) && m_tag[idx] != fpc) tag = "R1";
        if (fv && m_tag.exists(idx) && m_tag[idx] == fpc) begin
            if (m_kind[idx] == 2'b11) begin
                if (m_stk.size() > 0) begin
                    e_hit = 1'b1; e_tk = 1'b1; e_nx = m_stk.pop_back(); tag = "R6";
                end else begin
                    tag = "R8";
                end
            end else begin
                e_hit = 1'b1;
                e_tk  = m_tkn[idx];
                if (e_tk) e_nx = m_tgt[idx];
                tag = (m_kind[idx] == 2'b10) ? "R5" : "R3";
                if (m_kind[idx] == 2'b10) begin
                    m_stk.push_back(fpc + 4);
                    if (m_stk.size() > DEPTH) void'(m_stk.pop_front());
                end
            end
        end
        if (rq != "") tag = rq;
        chk(tag, "pred_hit", PC_W'(pred_hit), PC_W'(e_hit));
        chk(tag, "pred_taken", PC_W'(pred_taken), PC_W'(e_tk));
        chk(tag, "pred_next_pc", pred_next_pc, e_nx);
        if (uv) begin
            uidx = int'(upc[IDX_W+1:2]);
            m_tag[uidx] = upc; m_tgt[uidx] = utgt; m_tkn[uidx] = ut; m_kind[uidx] = uk;
        end
    endtask

    task automatic look(input logic [PC_W-1:0] fpc, input string rq);
        step(1'b1, fpc, 1'b0, '0, 2'b00, 1'b0, '0, rq);
    endtask

    task automatic install(input logic [PC_W-1:0] upc, input logic [1:0] uk,
                           input bit ut, input logic [PC_W-1:0] utgt);
        step(1'b0, 32'h0, 1'b1, upc, uk, ut, utgt, "R4");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; fetch_valid = 1'b0; fix_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        m_tag.delete(); m_tgt.delete(); m_tkn.delete(); m_kind.delete(); m_stk.delete();
        rst_n = 1'b1;
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        look(32'h100, "R10");                                     // reset state: miss
        // R7: same-cycle lookup sees old contents, next cycle sees new
        step(1'b1, 32'h100, 1'b1, 32'h100, 2'b00, 1'b1, 32'h200, "R7");
        look(32'h100, "R7");
        look(32'h140, "R1");                                      // alias of slot 0
        install(32'h100, 2'b00, 1'b0, 32'h260);                   // overwrite, not taken
        look(32'h100, "R4");
        install(32'h108, 2'b01, 1'b1, 32'h300);                   // jump
        look(32'h108, "R3");
        install(32'h110, 2'b11, 1'b0, 32'h0);                     // return
        look(32'h110, "R8");                                      // empty stack
        install(32'h10C, 2'b10, 1'b1, 32'h500);                   // call
        look(32'h10C, "R5");
        look(32'h110, "R6");
        look(32'h110, "R8");
        step(1'b0, 32'h108, 1'b0, '0, 2'b00, 1'b0, '0, "R2");     // fetch idle
        // R9: ten calls overflow the eight-entry stack, nine returns drain it
        for (int k = 0; k < 10; k++) install(32'h1000 + 32'(4 * k), 2'b10, 1'b1, 32'h8000);
        install(32'h1028, 2'b11, 1'b0, 32'h0);
        for (int k = 0; k < 10; k++) look(32'h1000 + 32'(4 * k), "R9");
        for (int k = 0; k < 9; k++) look(32'h1028, "R9");
        // Mixed random traffic, including aliasing and same-slot collisions
        for (int n = 0; n < 3000; n++) begin
            logic [PC_W-1:0] a;
            logic [PC_W-1:0] b;
            a = 32'h4000 + 32'(4 * ($urandom % 20)) + (($urandom % 4 == 0) ? 32'h40 : 32'h0);
            b = 32'h4000 + 32'(4 * ($urandom % 20)) + (($urandom % 4 == 0) ? 32'h40 : 32'h0);
            step(($urandom % 8) != 0, a, ($urandom % 10) < 3, b, 2'($urandom),
                 1'($urandom), 32'h9000 + 32'(4 * ($urandom % 256)), "");
        end
        // R10: reset clears entries and stack
        install(32'h4000, 2'b01, 1'b1, 32'h7000);
        do_reset();
        look(32'h4000, "R10");
        look(32'h1028, "R10");
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule